// File: doc/BRIEF.md
# Mesh Route Computation Unit

This unit decides, for one router of a two-dimensional mesh, which output port the head flit of a packet should leave through. Each cycle it takes the router's own column and row, the packet's destination column and row, a set of per-neighbour congestion flags and a policy selector. It returns a one-hot choice among Local, North, South, East and West, registered and qualified by a valid strobe one cycle after the request.

Three policies are available and can be switched request by request. The first is plain dimension order: finish the X distance first, then the Y distance. The second is west-first: all westward travel comes first, and after that the unit may adapt among the remaining productive directions. The third is a congestion-aware dynamic order: it prefers X, but moves in Y when the X neighbour is busy. Every policy is minimal: each chosen hop brings the packet one step closer. A destination that lies outside the mesh is flagged and sent to the Local port.

Top module: `mesh_route_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low after a cycle with `in_valid` low. A synchronous active-low reset clears `out_valid`, `out_port` and `out_err`.
- R2: `out_port` is one-hot while `out_valid` is high and all zero otherwise. Bit 0 is Local, bit 1 North (+Y), bit 2 South (-Y), bit 3 East (+X), bit 4 West (-X). `congest` bit 0 flags the North neighbour, bit 1 South, bit 2 East and bit 3 West.
- R3: When the current and destination coordinates are equal, the output is Local in every mode, whatever the congestion flags.
- R4: In mode 0 (dimension order) the unit moves East or West while the columns differ and North or South only once they match. Congestion flags are ignored.
- R5: In mode 1 (west-first), a destination column smaller than the current column always gives West, even when West is flagged congested.
- R6: In mode 1, with no westward distance left, East is preferred. If East is flagged congested, Y distance remains and the productive Y neighbour is not flagged, the Y direction is taken instead. West is never produced.
- R7: In mode 2 (dynamic), the productive X direction (East or West) is preferred. If that X neighbour is flagged congested, Y distance remains and the productive Y neighbour is not flagged, the productive Y direction is taken.
- R8: In modes 1 and 2, when both the productive X and the productive Y neighbours are flagged congested, the X direction is chosen.
- R9: Every non-Local output is a productive direction: it reduces the Manhattan distance to the destination by one.
- R10: A destination column not below the mesh width, or a destination row not below the mesh height, raises `out_err` together with a Local output.
- R11: Mode value 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| mode | input | 2 | Policy: 0 dimension order, 1 west-first, 2 dynamic, 3 as 0 |
| cur_x | input | XW = ceil(log2(MESH_X)) | Column of this router |
| cur_y | input | YW = ceil(log2(MESH_Y)) | Row of this router |
| dst_x | input | XW | Destination column |
| dst_y | input | YW | Destination row |
| congest | input | 4 | Neighbour busy flags: bit0 N, bit1 S, bit2 E, bit3 W |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_port | output | 5 | One-hot port: bit0 L, bit1 N, bit2 S, bit3 E, bit4 W |
| out_err | output | 1 | Destination outside the mesh |

## Verification
Every pair of router position and destination on the default 4x4 mesh is routed under every mode value and all sixteen congestion patterns. This separates the modes by whether they react to a busy X neighbour and whether westward travel can be diverted. It also exposes any tie-break error when both candidates are busy. A directed walk from (1,1) to (3,3) shows the dynamic mode detouring North when the East neighbour is busy, where dimension order turns at (3,1). A second, 3x3 instance receives destinations that the 2-bit fields can encode but the mesh does not hold, which separates the error path from normal routing.

// File: rtl/mrc_pkg.sv
// Shared definitions for the mesh route computation unit.
// Assumes the one-hot port layout L,N,S,E,W from bit 0 upward and a
// congestion vector ordered N,S,E,W, i.e. one below the port bit.
package mrc_pkg;

    localparam int PORT_W  = 5;
    localparam int P_LOCAL = 0;
    localparam int P_NORTH = 1;
    localparam int P_SOUTH = 2;
    localparam int P_EAST  = 3;
    localparam int P_WEST  = 4;

    localparam int DIR_W   = 4;
    localparam int C_NORTH = 0;
    localparam int C_SOUTH = 1;
    localparam int C_EAST  = 2;
    localparam int C_WEST  = 3;

    typedef enum logic [1:0] {
        MODE_XY  = 2'd0,
        MODE_WF  = 2'd1,
        MODE_DYN = 2'd2,
        MODE_RSV = 2'd3
    } route_mode_t;

    typedef logic [PORT_W-1:0] port_oh_t;

    localparam port_oh_t OH_LOCAL = port_oh_t'(1) << P_LOCAL;

endpackage

// File: rtl/mrc_axis_cmp.sv
// Compares one coordinate of this router against the destination on a
// single axis. Reports whether the destination lies on the increasing or
// decreasing side and whether the destination field exceeds the mesh.
// Assumes unsigned coordinates; LIMIT is the number of routers on the axis.
module mrc_axis_cmp #(
    parameter int W     = 2,
    parameter int LIMIT = 4
) (
    input  logic [W-1:0] here,
    input  logic [W-1:0] there,
    output logic         go_up,
    output logic         go_down,
    output logic         out_of_range
);
    localparam logic [W:0] LIM = (W+1)'(LIMIT);

    // Direction and range of the destination on this axis.
    always_comb begin
        go_up        = there > here;
        go_down      = there < here;
        out_of_range = {1'b0, there} >= LIM;
    end
endmodule

// File: rtl/mrc_policy.sv
// Applies the selected turn policy to a set of productive directions.
// Inputs are the productive mask (N,S,E,W layout as in mrc_pkg), the
// neighbour congestion flags and the mode. Output is a one-hot port.
// Assumes at most one of N/S and at most one of E/W is productive.
module mrc_policy
    import mrc_pkg::*;
(
    input  logic [DIR_W-1:0] want,
    input  logic [DIR_W-1:0] busy,
    input  logic [1:0]       mode,
    input  logic             arrived,
    input  logic             bad_dst,
    output port_oh_t         port
);
    logic     has_x, has_y, x_busy, y_busy, sidestep;
    port_oh_t x_oh, y_oh;

    // Candidate ports for each axis and their congestion state.
    always_comb begin
        has_x = want[C_EAST]  | want[C_WEST];
        has_y = want[C_NORTH] | want[C_SOUTH];
        x_oh  = '0;
        y_oh  = '0;
        x_oh[P_EAST]  = want[C_EAST];
        x_oh[P_WEST]  = want[C_WEST];
        y_oh[P_NORTH] = want[C_NORTH];
        y_oh[P_SOUTH] = want[C_SOUTH];
        x_busy = (want[C_EAST]  & busy[C_EAST])  | (want[C_WEST]  & busy[C_WEST]);
        y_busy = (want[C_NORTH] & busy[C_NORTH]) | (want[C_SOUTH] & busy[C_SOUTH]);
        sidestep = has_x & has_y & x_busy & ~y_busy;
    end

    // Policy selection with Local override for arrival and bad destination.
    always_comb begin
        unique case (route_mode_t'(mode))
            MODE_WF: begin
                if (want[C_WEST])  port = x_oh;
                else if (sidestep) port = y_oh;
                else if (has_x)    port = x_oh;
                else               port = y_oh;
            end
            MODE_DYN: begin
                if (sidestep)      port = y_oh;
                else if (has_x)    port = x_oh;
                else               port = y_oh;
            end
            default: begin
                port = has_x ? x_oh : y_oh;
            end
        endcase
        if (arrived || bad_dst) port = OH_LOCAL;
    end
endmodule

// File: rtl/mesh_route_unit.sv
// Route computation for one router of a MESH_X by MESH_Y mesh.
// Compares coordinates per axis, applies the selected policy and registers
// the one-hot port with a valid strobe one cycle later. No backpressure:
// a result is produced for every request. Synchronous active-low reset.
module mesh_route_unit
    import mrc_pkg::*;
#(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [XW-1:0]     cur_x,
    input  logic [YW-1:0]     cur_y,
    input  logic [XW-1:0]     dst_x,
    input  logic [YW-1:0]     dst_y,
    input  logic [DIR_W-1:0]  congest,
    output logic              out_valid,
    output logic [PORT_W-1:0] out_port,
    output logic              out_err
);
    logic             x_up, x_dn, x_bad, y_up, y_dn, y_bad;
    logic [DIR_W-1:0] want;
    logic             arrived, bad_dst;
    port_oh_t         next_port;

    mrc_axis_cmp #(.W(XW), .LIMIT(MESH_X)) u_cmp_x (
        .here(cur_x), .there(dst_x),
        .go_up(x_up), .go_down(x_dn), .out_of_range(x_bad)
    );

    mrc_axis_cmp #(.W(YW), .LIMIT(MESH_Y)) u_cmp_y (
        .here(cur_y), .there(dst_y),
        .go_up(y_up), .go_down(y_dn), .out_of_range(y_bad)
    );

    // Gather productive directions, arrival and destination error.
    always_comb begin
        want          = '0;
        want[C_EAST]  = x_up;
        want[C_WEST]  = x_dn;
        want[C_NORTH] = y_up;
        want[C_SOUTH] = y_dn;
        arrived = ~(x_up | x_dn | y_up | y_dn);
        bad_dst = x_bad | y_bad;
    end

    mrc_policy u_policy (
        .want(want), .busy(congest), .mode(mode),
        .arrived(arrived), .bad_dst(bad_dst), .port(next_port)
    );

    // Result register: port and error held only alongside a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_port  <= in_valid ? next_port : '0;
            out_err   <= in_valid & bad_dst;
        end
    end
endmodule

// File: rtl/mrc_checker.sv
// Temporal checks for mesh_route_unit, attached to every instance by bind.
// Relates the registered result to the request presented one cycle before.
module mrc_checker
    import mrc_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [XW-1:0]     cur_x,
    input logic [YW-1:0]     cur_y,
    input logic [XW-1:0]     dst_x,
    input logic [YW-1:0]     dst_y,
    input logic [DIR_W-1:0]  congest,
    input logic              out_valid,
    input logic [PORT_W-1:0] out_port,
    input logic              out_err
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_port_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_port) == 1);
    assert_port_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_port == '0);
    assert_arrival_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_x) == $past(dst_x) && $past(cur_y) == $past(dst_y))
        |-> out_port[P_LOCAL]);
    assert_west_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && $past(mode) == MODE_WF && $past(dst_x) < $past(cur_x))
        |-> out_port[P_WEST]);
    assert_east_productive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[P_EAST]) |-> $past(dst_x) > $past(cur_x));
    assert_west_productive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[P_WEST]) |-> $past(dst_x) < $past(cur_x));
    assert_north_productive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[P_NORTH]) |-> $past(dst_y) > $past(cur_y));
    assert_south_productive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[P_SOUTH]) |-> $past(dst_y) < $past(cur_y));
    assert_error_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_port[P_LOCAL]));
endmodule

bind mesh_route_unit mrc_checker #(.XW(XW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .congest(congest), .out_valid(out_valid), .out_port(out_port),
    .out_err(out_err)
);

// File: tb/mesh_route_unit_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them as results appear. A 3x3 instance covers range errors.
module mesh_route_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [3:0] congest = '0;
    logic       out_valid, out_err;
    logic [4:0] out_port;

    logic       o_valid_in = 1'b0;
    logic [1:0] o_cx = '0, o_cy = '0, o_dx = '0, o_dy = '0;
    logic       o_valid, o_err;
    logic [4:0] o_port;

    int checks = 0;
    int errors = 0;

    logic [5:0] q_exp[$];
    logic [4:0] q_ok[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_route_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .congest(congest), .out_valid(out_valid), .out_port(out_port),
        .out_err(out_err)
    );

    mesh_route_unit #(.MESH_X(3), .MESH_Y(3)) uut_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(o_valid_in), .mode(2'd0),
        .cur_x(o_cx), .cur_y(o_cy), .dst_x(o_dx), .dst_y(o_dy),
        .congest(4'b0000), .out_valid(o_valid), .out_port(o_port),
        .out_err(o_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Expected port from the requirements. Port bits L0 N1 S2 E3 W4.
    function automatic logic [4:0] model(input logic [1:0] m, input int cx, input int cy,
                                         input int dx, input int dy, input logic [3:0] cg);
        logic [4:0] xp, yp;
        bit hx, hy, xb, yb;
        xp = (dx > cx) ? 5'b01000 : (dx < cx) ? 5'b10000 : 5'b00000;
        yp = (dy > cy) ? 5'b00010 : (dy < cy) ? 5'b00100 : 5'b00000;
        hx = xp != 0;
        hy = yp != 0;
        xb = (dx > cx && cg[2]) || (dx < cx && cg[3]);
        yb = (dy > cy && cg[0]) || (dy < cy && cg[1]);
        if (!hx && !hy) return 5'b00001;
        if (m == 2'd1 && dx < cx) return xp;
        if ((m == 2'd1 || m == 2'd2) && hx && hy && xb && !yb) return yp;
        return hx ? xp : yp;
    endfunction

    function automatic string tag_of(input logic [1:0] m, input int cx, input int cy,
                                     input int dx, input int dy, input logic [3:0] cg);
        bit xb, yb;
        xb = (dx > cx && cg[2]) || (dx < cx && cg[3]);
        yb = (dy > cy && cg[0]) || (dy < cy && cg[1]);
        if (cx == dx && cy == dy) return "R3";
        if (m == 2'd3) return "R11";
        if (m == 2'd0) return "R4";
        if (m == 2'd1 && dx < cx) return "R5";
        if (cx != dx && cy != dy && xb && yb) return "R8";
        return (m == 2'd1) ? "R6" : "R7";
    endfunction

    // Driver: present one request and record its expected outcome.
    task automatic send(input logic [1:0] m, input int cx, input int cy,
                        input int dx, input int dy, input logic [3:0] cg);
        logic [4:0] ok_mask;
        @(negedge clk);
        in_valid = 1'b1;
        mode = m;
        cur_x = 2'(cx); cur_y = 2'(cy); dst_x = 2'(dx); dst_y = 2'(dy);
        congest = cg;
        ok_mask = 5'b00000;
        if (dy > cy) ok_mask[1] = 1'b1;
        if (dy < cy) ok_mask[2] = 1'b1;
        if (dx > cx) ok_mask[3] = 1'b1;
        if (dx < cx) ok_mask[4] = 1'b1;
        if (ok_mask == 0) ok_mask = 5'b00001;
        q_exp.push_back({1'b0, model(m, cx, cy, dx, dy, cg)});
        q_ok.push_back(ok_mask);
        q_tag.push_back(tag_of(m, cx, cy, dx, dy, cg));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each result a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R1", 1, 0);
                end else begin
                    logic [5:0] e;
                    logic [4:0] okm;
                    string t;
                    e = q_exp.pop_front();
                    okm = q_ok.pop_front();
                    t = q_tag.pop_front();
                    check({out_err, out_port} == e, t, {out_err, out_port}, e);
                    check((out_port & ~okm) == 0, "R9", out_port, okm);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is still applied
        check(out_valid == 1'b0 && out_port == 5'b0 && out_err == 1'b0, "R1",
              {out_err, out_valid, out_port}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R2 idle: no request gives no strobe and an all-zero port
        check(out_valid == 1'b0 && out_port == 5'b0, "R2", {out_valid, out_port}, 0);

        // Directed walk (1,1)->(3,3): R4 turns at (3,1); R7 detours North
        send(2'd0, 1, 1, 3, 3, 4'b0100);
        send(2'd2, 1, 1, 3, 3, 4'b0100);
        send(2'd2, 1, 2, 3, 3, 4'b0100);
        send(2'd2, 1, 3, 3, 3, 4'b0100);
        send(2'd2, 2, 3, 3, 3, 4'b0000);
        // R5: west forced even when West is busy; R8 tie-break
        send(2'd1, 3, 0, 0, 3, 4'b1000);
        send(2'd2, 3, 0, 0, 3, 4'b1001);
        idle();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);

        // Exhaustive sweep: every position, destination, mode and congestion
        for (int m = 0; m < 4; m++)
            for (int cg = 0; cg < 16; cg++)
                for (int cx = 0; cx < 4; cx++)
                    for (int cy = 0; cy < 4; cy++)
                        for (int dx = 0; dx < 4; dx++)
                            for (int dy = 0; dy < 4; dy++)
                                send(2'(m), cx, cy, dx, dy, 4'(cg));
        idle();
        repeat (3) @(negedge clk);
        check(q_exp.size() == 0, "R1", q_exp.size(), 0);

        // R10 on the 3x3 instance: column 3 and row 3 lie outside the mesh
        @(negedge clk);
        o_valid_in = 1'b1; o_cx = 2'd0; o_cy = 2'd0; o_dx = 2'd3; o_dy = 2'd1;
        @(posedge clk); #(CLK_PERIOD/4);
        check(o_valid && o_err && o_port == 5'b00001, "R10", {o_err, o_port}, 6'b100001);
        @(negedge clk);
        o_dx = 2'd1; o_dy = 2'd3;
        @(posedge clk); #(CLK_PERIOD/4);
        check(o_valid && o_err && o_port == 5'b00001, "R10", {o_err, o_port}, 6'b100001);
        @(negedge clk);
        o_dx = 2'd2; o_dy = 2'd2;
        @(posedge clk); #(CLK_PERIOD/4);
        check(o_valid && !o_err && o_port == 5'b01000, "R10", {o_err, o_port}, 6'b001000);
        @(negedge clk);
        o_valid_in = 1'b0;
        @(posedge clk); #(CLK_PERIOD/4);
        check(!o_valid && !o_err, "R10", {o_valid, o_err}, 0);

        finish_run();
    end
endmodule